// File: doc/BRIEF.md
# Commit Trap Sequencer

This block controls how a faulting instruction at the head of the reorder buffer is retired and how the pipeline is flushed afterwards. The commit stage feeds it, each cycle, a description of the head entry: whether it is valid, whether it carries a fault, whether it is a store, and whether the fault is a syscall-retry kind. It also receives the store-drain state, the number of instructions already committed earlier in the same cycle, the ROB empty flag and two sequence numbers.

A fault is held at the head until every outstanding store has drained and no older instruction has committed in the current cycle. The sequencer then marks the head completed, pulses a trap-invoke strobe to the CSR logic and enters a pending state. It stays there for a programmable latency, and normal commit is blocked for that time. When the latency runs out, it broadcasts a full squash with the redirect PC and the squash sequence number. It then waits in a ROB-squashing state until the ROB reports that the squash has finished.

Top module: `commit_trap_seq`

## Requirements
- R1: After reset, status_o is 0 (running) and trap_invoke_o, squash_o, trap_squash_o, rob_squashing_o, trap_pending_o and commit_block_o are low.
- R2: While running, a valid faulting head does not raise trap_invoke_o unless stores_drained_i is high and prior_commits_i is zero in the same cycle.
- R3: While running, a valid head with no fault raises head_complete_o in the same cycle exactly when head_is_store_i is low. An invalid head never raises it.
- R4: When the gate of R2 opens, trap_invoke_o and head_complete_o are high in that cycle, and status_o is 1 (trap pending) with trap_pending_o high from the next cycle.
- R5: squash_o is raised exactly L+1 cycles after the trap_invoke_o cycle. L is the 8-bit value retry_lat_i when head_syscall_retry_i is high at invoke, and trap_lat_i otherwise, both sampled at invoke. L=0 gives the squash on the very next cycle.
- R6: Whenever status_o is not 0, head_complete_o and trap_invoke_o are low and commit_block_o is high.
- R7: In the squash cycle, squash_seq_o is head_seq_i minus one (modulo 2^SEQ_W, so 0 gives all ones), or last_commit_seq_i when rob_empty_i is high.
- R8: squash_o and trap_squash_o are high for exactly one cycle per trap. In that cycle rob_squashing_o is high, mispredict_o is low and redirect_pc_o equals trap_pc_i.
- R9: From the cycle after the squash, status_o is 2 (ROB squashing), rob_squashing_o stays high and trap_pending_o is low. status_o returns to 0 on the cycle after squash_done_i is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| head_vld_i | input | 1 | ROB head entry valid |
| head_fault_i | input | 1 | Head entry carries a fault |
| head_is_store_i | input | 1 | Head entry is a store |
| head_syscall_retry_i | input | 1 | Head fault is a syscall-retry fault |
| stores_drained_i | input | 1 | All outstanding stores are flushed |
| prior_commits_i | input | CNT_W | Instructions committed earlier this cycle |
| rob_empty_i | input | 1 | ROB holds no entries |
| head_seq_i | input | SEQ_W | Sequence number of the head entry |
| last_commit_seq_i | input | SEQ_W | Sequence number of the last committed instruction |
| trap_lat_i | input | LAT_W | Trap latency for ordinary faults |
| retry_lat_i | input | LAT_W | Trap latency for syscall-retry faults |
| trap_pc_i | input | PC_W | Handler PC supplied by the trap logic |
| squash_done_i | input | 1 | ROB reports the squash is complete |
| head_complete_o | output | 1 | Mark the head entry completed |
| trap_invoke_o | output | 1 | One-cycle strobe to invoke the trap |
| trap_pending_o | output | 1 | Trap latency running |
| commit_block_o | output | 1 | Normal commit is blocked |
| squash_o | output | 1 | Squash-all broadcast |
| rob_squashing_o | output | 1 | ROB squash in progress |
| trap_squash_o | output | 1 | Squash originates from a trap |
| mispredict_o | output | 1 | Mispredict field of the broadcast (always cleared by this block) |
| squash_seq_o | output | SEQ_W | Youngest sequence number kept |
| redirect_pc_o | output | PC_W | Fetch redirect PC |
| status_o | output | 2 | 0 running, 1 trap pending, 2 ROB squashing |

## Verification
The hardest case to reach from the ports is the exact squash cycle. It depends on which latency was captured at the invoke edge, while the fault sits at the head through several blocked cycles. The bench holds the fault at the head and first walks it through gate-closed cycles, with stores undrained and then with a non-zero prior count. Only then does it open the gate. It changes the latency inputs right after invoke, to show that the captured value rules. It sweeps L over 0 to 5 for both fault kinds and both ROB-empty settings, and checks that squash_o is low in every cycle except cycle L+1. The sequence numbers used include 0, which exercises the wrap of R7.

// File: rtl/cts_pkg.sv
package cts_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PEND = 2'd1,
    ST_SQSH = 2'd2
  } cts_state_e;
endpackage

// File: rtl/cts_gate.sv
// Decides whether the head entry may retire this cycle.
module cts_gate #(
  parameter int CNT_W = 3
) (
  input  logic             running_i,
  input  logic             head_vld_i,
  input  logic             head_fault_i,
  input  logic             head_is_store_i,
  input  logic             stores_drained_i,
  input  logic [CNT_W-1:0] prior_commits_i,
  output logic             proceed_o,
  output logic             complete_o
);
  logic fault_head;
  logic clean_head;

  always_comb begin
    fault_head = running_i && head_vld_i && head_fault_i;
    clean_head = running_i && head_vld_i && !head_fault_i && !head_is_store_i;
    proceed_o  = fault_head && stores_drained_i && (prior_commits_i == '0);
    complete_o = clean_head || proceed_o;
  end
endmodule

// File: rtl/cts_timer.sv
// Down-counter for the trap latency.
module cts_timer #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LAT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [LAT_W-1:0] cnt_q;
  logic [LAT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (run_i && (cnt_q != '0));
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R5: the captured value is the one loaded
  p_load_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
  // R5: the counter steps down by one while running
  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cts_squash.sv
// Forms the squash broadcast fields.
module cts_squash #(
  parameter int SEQ_W = 16,
  parameter int PC_W  = 64
) (
  input  logic             fire_i,
  input  logic             rob_empty_i,
  input  logic [SEQ_W-1:0] head_seq_i,
  input  logic [SEQ_W-1:0] last_commit_seq_i,
  input  logic [PC_W-1:0]  trap_pc_i,
  output logic [SEQ_W-1:0] squash_seq_o,
  output logic [PC_W-1:0]  redirect_pc_o,
  output logic             mispredict_o
);
  always_comb begin
    squash_seq_o  = '0;
    redirect_pc_o = '0;
    mispredict_o  = 1'b0;
    if (fire_i) begin
      squash_seq_o  = rob_empty_i ? last_commit_seq_i : (head_seq_i - 1'b1);
      redirect_pc_o = trap_pc_i;
    end
  end
endmodule

// File: rtl/commit_trap_seq.sv
module commit_trap_seq
  import cts_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 64,
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_vld_i,
  input  logic             head_fault_i,
  input  logic             head_is_store_i,
  input  logic             head_syscall_retry_i,
  input  logic             stores_drained_i,
  input  logic [CNT_W-1:0] prior_commits_i,
  input  logic             rob_empty_i,
  input  logic [SEQ_W-1:0] head_seq_i,
  input  logic [SEQ_W-1:0] last_commit_seq_i,
  input  logic [LAT_W-1:0] trap_lat_i,
  input  logic [LAT_W-1:0] retry_lat_i,
  input  logic [PC_W-1:0]  trap_pc_i,
  input  logic             squash_done_i,
  output logic             head_complete_o,
  output logic             trap_invoke_o,
  output logic             trap_pending_o,
  output logic             commit_block_o,
  output logic             squash_o,
  output logic             rob_squashing_o,
  output logic             trap_squash_o,
  output logic             mispredict_o,
  output logic [SEQ_W-1:0] squash_seq_o,
  output logic [PC_W-1:0]  redirect_pc_o,
  output logic [1:0]       status_o
);
  cts_state_e       state_q, state_d;
  logic             running;
  logic             proceed;
  logic             tmr_zero;
  logic             fire;
  logic [LAT_W-1:0] lat_sel;

  assign running = (state_q == ST_RUN);
  assign lat_sel = head_syscall_retry_i ? retry_lat_i : trap_lat_i;

  cts_gate #(.CNT_W(CNT_W)) u_gate (
    .running_i        (running),
    .head_vld_i       (head_vld_i),
    .head_fault_i     (head_fault_i),
    .head_is_store_i  (head_is_store_i),
    .stores_drained_i (stores_drained_i),
    .prior_commits_i  (prior_commits_i),
    .proceed_o        (proceed),
    .complete_o       (head_complete_o)
  );

  cts_timer #(.LAT_W(LAT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (proceed),
    .load_val_i (lat_sel),
    .run_i      (state_q == ST_PEND),
    .zero_o     (tmr_zero)
  );

  assign fire = (state_q == ST_PEND) && tmr_zero;

  cts_squash #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_squash (
    .fire_i            (fire),
    .rob_empty_i       (rob_empty_i),
    .head_seq_i        (head_seq_i),
    .last_commit_seq_i (last_commit_seq_i),
    .trap_pc_i         (trap_pc_i),
    .squash_seq_o      (squash_seq_o),
    .redirect_pc_o     (redirect_pc_o),
    .mispredict_o      (mispredict_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (proceed)       state_d = ST_PEND;
      ST_PEND: if (tmr_zero)      state_d = ST_SQSH;
      ST_SQSH: if (squash_done_i) state_d = ST_RUN;
      default:                    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign trap_invoke_o   = proceed;
  assign trap_pending_o  = (state_q == ST_PEND);
  assign commit_block_o  = !running;
  assign squash_o        = fire;
  assign trap_squash_o   = fire;
  assign rob_squashing_o = fire || (state_q == ST_SQSH);
  assign status_o        = state_q;

  // R2: the invoke only passes through an open gate
  p_gate_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_invoke_o |-> (stores_drained_i && prior_commits_i == '0 && head_fault_i));
  // R4: the invoke leads to the pending state
  p_invoke_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_invoke_o |=> (status_o == 2'd1 && trap_pending_o));
  // R5: a zero latency squashes on the next cycle
  p_zero_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_invoke_o && lat_sel == '0) |=> squash_o);
  // R6: no retirement outside the running state
  p_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != 2'd0) |-> (!head_complete_o && !trap_invoke_o && commit_block_o));
  // R7: squash sequence number when the ROB holds entries
  p_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_o && !rob_empty_i) |-> (squash_seq_o == head_seq_i - 1'b1));
  // R8: single squash pulse followed by the squashing state
  p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |=> !squash_o);
  // R9: after the squash the status is ROB squashing
  p_after_squash_r9: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |=> (status_o == 2'd2 && rob_squashing_o && !trap_pending_o));
endmodule

// File: tb/tb_commit_trap_seq.sv
module tb_commit_trap_seq;
  localparam int CNT_W = 3;
  localparam int SEQ_W = 16;
  localparam int PC_W  = 64;
  localparam int LAT_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic head_vld, head_fault, head_store, head_retry, drained, rob_empty, sq_done;
  logic [CNT_W-1:0] prior;
  logic [SEQ_W-1:0] hseq, lseq;
  logic [LAT_W-1:0] tlat, rlat;
  logic [PC_W-1:0]  tpc;
  logic head_cmp, invoke, pending, blk, squash, robsq, tsq, mispred;
  logic [SEQ_W-1:0] sqseq;
  logic [PC_W-1:0]  rpc;
  logic [1:0]       status;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  commit_trap_seq #(.CNT_W(CNT_W), .SEQ_W(SEQ_W), .PC_W(PC_W), .LAT_W(LAT_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .head_vld_i(head_vld), .head_fault_i(head_fault), .head_is_store_i(head_store),
    .head_syscall_retry_i(head_retry), .stores_drained_i(drained),
    .prior_commits_i(prior), .rob_empty_i(rob_empty), .head_seq_i(hseq),
    .last_commit_seq_i(lseq), .trap_lat_i(tlat), .retry_lat_i(rlat),
    .trap_pc_i(tpc), .squash_done_i(sq_done),
    .head_complete_o(head_cmp), .trap_invoke_o(invoke), .trap_pending_o(pending),
    .commit_block_o(blk), .squash_o(squash), .rob_squashing_o(robsq),
    .trap_squash_o(tsq), .mispredict_o(mispred), .squash_seq_o(sqseq),
    .redirect_pc_o(rpc), .status_o(status)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // advance to the next sampling point: inputs change at negedge, outputs read 1ns later
  task automatic step;
    @(negedge clk);
    #1;
  endtask

  task automatic run_trap(input int lat, input bit retry, input bit empty,
                          input logic [SEQ_W-1:0] hs, input logic [SEQ_W-1:0] ls);
    logic [SEQ_W-1:0] exp_seq;
    exp_seq = empty ? ls : hs - 1'b1;
    @(negedge clk);
    head_vld = 1; head_fault = 1; head_store = 0; head_retry = retry;
    drained = 0; prior = 0; rob_empty = empty; hseq = hs; lseq = ls;
    tpc = {32'hc0de_0000, 16'h0, hs};
    tlat = retry ? 8'd200 : lat[7:0];
    rlat = retry ? lat[7:0] : 8'd200;
    #1;
    check("R2 stores pending", {63'd0, invoke}, 64'd0);
    check("R2 no completion", {63'd0, head_cmp}, 64'd0);
    @(negedge clk); drained = 1; prior = 3'd2; #1;
    check("R2 prior commits", {63'd0, invoke}, 64'd0);
    @(negedge clk); prior = 0; #1;
    check("R4 invoke", {63'd0, invoke}, 64'd1);
    check("R4 complete", {63'd0, head_cmp}, 64'd1);
    check("R5 no early squash", {63'd0, squash}, 64'd0);
    for (int k = 0; k <= lat; k++) begin
      @(negedge clk);
      tlat = 8'd0; rlat = 8'd0;   // later changes must not matter
      #1;
      if (k == 0) check("R4 pending status", {62'd0, status}, 64'd1);
      check("R5 squash timing", {63'd0, squash}, (k == lat) ? 64'd1 : 64'd0);
      check("R6 blocked", {61'd0, blk, head_cmp, invoke}, 64'd4);
      if (k == lat) begin
        check("R7 squash seq", {48'd0, sqseq}, {48'd0, exp_seq});
        check("R8 trap squash", {61'd0, tsq, robsq, mispred}, 64'd6);
        check("R8 redirect pc", rpc, tpc);
      end
    end
    @(negedge clk); head_vld = 0; head_fault = 0; #1;
    check("R9 squashing status", {62'd0, status}, 64'd2);
    check("R9 flags", {60'd0, robsq, pending, squash, tsq}, 64'd8);
    check("R6 blocked in squash", {63'd0, blk}, 64'd1);
    @(negedge clk); #1;
    check("R9 waits for done", {62'd0, status}, 64'd2);
    @(negedge clk); sq_done = 1; #1;
    @(negedge clk); sq_done = 0; #1;
    check("R9 back to running", {62'd0, status}, 64'd0);
    check("R9 unblocked", {62'd0, blk, robsq}, 64'd0);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0;
    head_vld = 0; head_fault = 0; head_store = 0; head_retry = 0; drained = 0;
    rob_empty = 0; sq_done = 0; prior = 0; hseq = 0; lseq = 0; tlat = 0; rlat = 0; tpc = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset status", {62'd0, status}, 64'd0);
    check("R1 reset strobes", {58'd0, invoke, squash, tsq, robsq, pending, blk}, 64'd0);
    @(negedge clk); rst_n = 1; #1;
    check("R1 after release", {62'd0, status}, 64'd0);

    // R3: sweep head kinds while running
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      head_vld = p[1]; head_fault = 0; head_store = p[0]; drained = 1; #1;
      check("R3 completion", {63'd0, head_cmp}, (p == 2) ? 64'd1 : 64'd0);
      check("R3 no invoke", {63'd0, invoke}, 64'd0);
    end
    @(negedge clk); head_vld = 0; head_fault = 1; #1;
    check("R3 invalid faulting head", {62'd0, head_cmp, invoke}, 64'd0);
    head_fault = 0;

    // R5 R7 sweep: latency, fault kind, ROB empty, sequence wrap
    for (int l = 0; l < 6; l++)
      for (int r = 0; r < 2; r++)
        for (int e = 0; e < 2; e++)
          run_trap(l, r[0], e[0], (l == 0) ? 16'h0000 : 16'(l * 16'h1111 + r),
                   16'(16'h0abc + l));
    run_trap(255, 1'b0, 1'b0, 16'h8000, 16'h7f00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule